// File: doc/BRIEF.md
# USB Device Interrupt and Control Registers

This block holds the interrupt and control registers of a low-speed USB device controller. Single-cycle event pulses from the link layer are latched into an eight-bit status register. Each status bit is gated by a matching bit of a mask register, and the gated bits are combined into one interrupt request to the CPU. A recurring error or start-of-frame event that arrives before software has cleared the earlier one is recorded as an interrupt overrun.

A four-bit control register drives the resume signalling, the regulator power-down, forced suspend and forced reset. While forced reset is held, the interface ignores link events and keeps the address and endpoint registers cleared. When software releases forced reset, the block records a USB reset in the status register. The CPU reaches the three registers through a byte-wide port. Writes take effect on the clock edge. Reads are combinational.

Top module: `usb_irq_ctrl`

## Requirements
- R1: Status bit positions are suspend=7, data overrun=6, correct transfer=5, error=4, interrupt overrun=3, end of suspend=2, USB reset=1, start of frame=0. Each event pulse sets its bit at the next clock edge, and the bit stays set until software clears it.
- R2: A write to the status register (address 0) clears every bit written 0 and keeps every bit written 1. A hardware set in the same cycle overrides the clear.
- R3: An error or start-of-frame event sets the interrupt-overrun bit when that status bit is already 1 before the edge, even if the same write clears it.
- R4: `irq_o` is high when some status bit and its mask bit (address 1) are both 1 and `cpu_irq_dis_i` is low.
- R5: After reset the status and mask registers read 0x00 and the control register (address 2) reads 0x06. Control bit 3 is resume, bit 2 is power-down, bit 1 is force-suspend and bit 0 is force-reset.
- R6: Control bits 7:4 always read 0, and address 3 reads 0x00.
- R7: Bus activity while force-suspend is 1 sets the end-of-suspend bit and clears force-suspend. While force-suspend is 0, bus activity has no effect.
- R8: `wake_o` is high while the end-of-suspend status bit and its mask bit are both 1, whatever `cpu_irq_dis_i` is.
- R9: While force-reset is 1, all event inputs are ignored and `epreg_clr_o` is high. The write that clears force-reset sets the USB reset status bit.
- R10: A bus reset event drives `epreg_clr_o` high in the same cycle.
- R11: The end of a resume sequence sets the start-of-frame bit, with the same overrun rule as a start-of-frame event.
- R12: `resume_o` follows control bit 3, and only a software write changes that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Register select: 0 status, 1 mask, 2 control |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| ev_susp_i | input | 1 | Suspend event pulse |
| ev_dovr_i | input | 1 | Data overrun event pulse |
| ev_ctr_i | input | 1 | Correct transfer event pulse |
| ev_err_i | input | 1 | Error event pulse |
| ev_activity_i | input | 1 | Bus activity pulse |
| ev_bus_rst_i | input | 1 | Bus reset detected pulse |
| ev_sof_i | input | 1 | Keep-alive strobe pulse |
| ev_resume_end_i | input | 1 | End of resume sequence pulse |
| cpu_irq_dis_i | input | 1 | CPU global interrupt disable |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request |
| resume_o | output | 1 | Force resume signalling on the bus |
| pdwn_o | output | 1 | Regulator power-down |
| fsusp_o | output | 1 | Suspend mode active |
| epreg_clr_o | output | 1 | Clear address and endpoint registers |

## Verification
The assertions assume that event inputs are clean single-cycle pulses that are synchronous to `clk_i`, and that register port inputs are stable around the rising edge. They also assume that a control write and a bus activity pulse in the same cycle resolve in favour of the hardware clear. The bench changes every input at the falling edge, holds each event for exactly one cycle, and samples outputs one falling edge after the edge that consumes the stimulus. It includes cycles where a software clear and a hardware set collide, so the override and overrun rules are exercised.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned CTL_W  = 4;

  // status / mask bit positions
  localparam int unsigned B_SUSP  = 7;
  localparam int unsigned B_DOVR  = 6;
  localparam int unsigned B_CTR   = 5;
  localparam int unsigned B_ERR   = 4;
  localparam int unsigned B_IOVR  = 3;
  localparam int unsigned B_ESUSP = 2;
  localparam int unsigned B_RST   = 1;
  localparam int unsigned B_SOF   = 0;

  // control bit positions
  localparam int unsigned C_RESUME = 3;
  localparam int unsigned C_PDWN   = 2;
  localparam int unsigned C_FSUSP  = 1;
  localparam int unsigned C_FRES   = 0;

  localparam logic [CTL_W-1:0] CTL_RST_VAL = 4'b0110;
endpackage

// File: rtl/usb_irq_status.sv
module usb_irq_status
  import usb_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] ev_set_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] sts_o
);
  logic [REG_W-1:0] sts_q, hw_set, kept;
  logic             ovr;

  // overrun judged on the value held before this edge
  assign ovr = (ev_set_i[B_ERR] & sts_q[B_ERR]) | (ev_set_i[B_SOF] & sts_q[B_SOF]);

  always_comb begin
    hw_set         = ev_set_i;
    hw_set[B_IOVR] = ev_set_i[B_IOVR] | ovr;
    kept           = wr_i ? (sts_q & wdata_i) : sts_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= kept | hw_set;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/usb_irq_ctl.sv
module usb_irq_ctl
  import usb_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             wake_i,     // activity qualified by suspend
  output logic [CTL_W-1:0] ctl_o,
  output logic             release_o   // force-reset being cleared this cycle
);
  logic [CTL_W-1:0] ctl_q, ctl_d;

  always_comb begin
    ctl_d = wr_i ? wdata_i : ctl_q;
    if (wake_i) ctl_d[C_FSUSP] = 1'b0;  // hardware clear wins
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= CTL_RST_VAL;
    else         ctl_q <= ctl_d;
  end

  assign release_o = wr_i & ctl_q[C_FRES] & ~wdata_i[C_FRES];
  assign ctl_o     = ctl_q;
endmodule

// File: rtl/usb_irq_gen.sv
module usb_irq_gen
  import usb_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] sts_i,
  input  logic             dis_i,
  output logic [REG_W-1:0] msk_o,
  output logic             irq_o,
  output logic             wake_o
);
  logic [REG_W-1:0] msk_q;
  logic [REG_W-1:0] pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   msk_q <= '0;
    else if (wr_i) msk_q <= wdata_i;
  end

  assign pend   = sts_i & msk_q;
  assign irq_o  = (|pend) & ~dis_i;
  assign wake_o = pend[B_ESUSP];
  assign msk_o  = msk_q;
endmodule

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned ADDR_STS = 0,
  parameter int unsigned ADDR_MSK = 1,
  parameter int unsigned ADDR_CTL = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              ev_susp_i,
  input  logic              ev_dovr_i,
  input  logic              ev_ctr_i,
  input  logic              ev_err_i,
  input  logic              ev_activity_i,
  input  logic              ev_bus_rst_i,
  input  logic              ev_sof_i,
  input  logic              ev_resume_end_i,
  input  logic              cpu_irq_dis_i,
  output logic              irq_o,
  output logic              wake_o,
  output logic              resume_o,
  output logic              pdwn_o,
  output logic              fsusp_o,
  output logic              epreg_clr_o
);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(ADDR_STS);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(ADDR_MSK);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ADDR_CTL);

  logic [REG_W-1:0] sts_q, msk_q, ev_set;
  logic [CTL_W-1:0] ctl_q;
  logic             fres_q, ev_on, wake_ev, release_pls;
  logic             wr_sts, wr_msk, wr_ctl;

  assign wr_sts = reg_we_i & (reg_addr_i == A_STS);
  assign wr_msk = reg_we_i & (reg_addr_i == A_MSK);
  assign wr_ctl = reg_we_i & (reg_addr_i == A_CTL);

  assign fres_q  = ctl_q[C_FRES];
  assign ev_on   = ~fres_q;
  assign wake_ev = ev_on & ev_activity_i & ctl_q[C_FSUSP];

  always_comb begin
    ev_set          = '0;
    ev_set[B_SUSP]  = ev_on & ev_susp_i;
    ev_set[B_DOVR]  = ev_on & ev_dovr_i;
    ev_set[B_CTR]   = ev_on & ev_ctr_i;
    ev_set[B_ERR]   = ev_on & ev_err_i;
    ev_set[B_ESUSP] = wake_ev;
    ev_set[B_RST]   = (ev_on & ev_bus_rst_i) | release_pls;
    ev_set[B_SOF]   = ev_on & (ev_sof_i | ev_resume_end_i);
  end

  usb_irq_status i_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_set_i (ev_set),
    .wr_i     (wr_sts),
    .wdata_i  (reg_wdata_i),
    .sts_o    (sts_q)
  );

  usb_irq_ctl i_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_ctl),
    .wdata_i   (reg_wdata_i[CTL_W-1:0]),
    .wake_i    (wake_ev),
    .ctl_o     (ctl_q),
    .release_o (release_pls)
  );

  usb_irq_gen i_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_msk),
    .wdata_i (reg_wdata_i),
    .sts_i   (sts_q),
    .dis_i   (cpu_irq_dis_i),
    .msk_o   (msk_q),
    .irq_o   (irq_o),
    .wake_o  (wake_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_STS:   reg_rdata_o = sts_q;
      A_MSK:   reg_rdata_o = msk_q;
      A_CTL:   reg_rdata_o = {{(REG_W-CTL_W){1'b0}}, ctl_q};
      default: reg_rdata_o = '0;
    endcase
  end

  assign resume_o    = ctl_q[C_RESUME];
  assign pdwn_o      = ctl_q[C_PDWN];
  assign fsusp_o     = ctl_q[C_FSUSP];
  assign epreg_clr_o = fres_q | ev_bus_rst_i;
endmodule

// File: rtl/usb_irq_ctrl_chk.sv
module usb_irq_ctrl_chk
  import usb_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned ADDR_CTL = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_we_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic [REG_W-1:0]  sts_q,
  input logic              fres_q,
  input logic              ev_err_i,
  input logic              ev_ctr_i,
  input logic              ev_activity_i,
  input logic              ev_bus_rst_i,
  input logic              fsusp_o,
  input logic              resume_o,
  input logic              epreg_clr_o
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ADDR_CTL);

  logic ctl_wr;
  assign ctl_wr = reg_we_i & (reg_addr_i == A_CTL);

  a_r3_err_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_err_i && !fres_q && sts_q[B_ERR]) |=> sts_q[B_IOVR]);

  a_r6_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_CTL) |-> (reg_rdata_o[REG_W-1:CTL_W] == '0));

  a_r7_wake_clears_fsusp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_activity_i && fsusp_o && !fres_q) |=> (!fsusp_o && sts_q[B_ESUSP]));

  a_r9_release_sets_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && fres_q && !reg_wdata_i[C_FRES]) |=> sts_q[B_RST]);

  a_r9_events_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fres_q && ev_ctr_i && !sts_q[B_CTR]) |=> !sts_q[B_CTR]);

  a_r10_bus_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_bus_rst_i |-> epreg_clr_o);

  a_r12_resume_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_wr |=> $stable(resume_o));
endmodule

bind usb_irq_ctrl usb_irq_ctrl_chk #(.ADDR_W(ADDR_W), .ADDR_CTL(ADDR_CTL)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_addr_i    (reg_addr_i),
  .reg_we_i      (reg_we_i),
  .reg_wdata_i   (reg_wdata_i),
  .reg_rdata_o   (reg_rdata_o),
  .sts_q         (sts_q),
  .fres_q        (fres_q),
  .ev_err_i      (ev_err_i),
  .ev_ctr_i      (ev_ctr_i),
  .ev_activity_i (ev_activity_i),
  .ev_bus_rst_i  (ev_bus_rst_i),
  .fsusp_o       (fsusp_o),
  .resume_o      (resume_o),
  .epreg_clr_o   (epreg_clr_o)
);

// File: tb/test_usb_irq_ctrl.sv
module test_usb_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] ev = '0;  // {susp,dovr,ctr,err,activity,bus_rst,sof,resume_end}
  logic       dis = 1'b0;
  logic       irq, wake, resume, pdwn, fsusp, epclr;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  usb_irq_ctrl i_usb_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ev_susp_i(ev[7]), .ev_dovr_i(ev[6]), .ev_ctr_i(ev[5]), .ev_err_i(ev[4]),
    .ev_activity_i(ev[3]), .ev_bus_rst_i(ev[2]), .ev_sof_i(ev[1]),
    .ev_resume_end_i(ev[0]), .cpu_irq_dis_i(dis),
    .irq_o(irq), .wake_o(wake), .resume_o(resume), .pdwn_o(pdwn),
    .fsusp_o(fsusp), .epreg_clr_o(epclr)
  );

  // {events, write-status, write data, expected status after edge, req id}
  localparam int NV = 17;
  localparam logic [28:0] VEC [NV] = '{
    {8'h02, 1'b0, 8'h00, 8'h01, 4'd1},  // sof
    {8'h02, 1'b0, 8'h00, 8'h09, 4'd3},  // sof again -> overrun
    {8'h00, 1'b1, 8'hF6, 8'h00, 4'd2},  // clear sof + overrun
    {8'h10, 1'b0, 8'h00, 8'h10, 4'd1},  // err
    {8'h10, 1'b1, 8'hEF, 8'h18, 4'd3},  // err + clear: set wins, overrun
    {8'h00, 1'b1, 8'h00, 8'h00, 4'd2},
    {8'hE0, 1'b0, 8'h00, 8'hE0, 4'd1},  // susp, dovr, ctr
    {8'h00, 1'b1, 8'hBF, 8'hA0, 4'd2},  // clear dovr only
    {8'h00, 1'b1, 8'hFF, 8'hA0, 4'd2},  // ones keep
    {8'h08, 1'b0, 8'h00, 8'hA4, 4'd7},  // activity while suspended
    {8'h08, 1'b0, 8'h00, 8'hA4, 4'd7},  // activity not suspended: no effect
    {8'h04, 1'b0, 8'h00, 8'hA6, 4'd1},  // bus reset
    {8'h01, 1'b0, 8'h00, 8'hA7, 4'd11}, // resume end -> sof
    {8'h00, 1'b1, 8'h00, 8'h00, 4'd2},
    {8'h12, 1'b0, 8'h00, 8'h11, 4'd1},  // err + sof
    {8'h12, 1'b0, 8'h00, 8'h19, 4'd3},  // both again -> overrun
    {8'h00, 1'b1, 8'h00, 8'h00, 4'd2}
  };

  function automatic string rq(input logic [3:0] id);
    case (id)
      4'd1: return "R1"; 4'd2: return "R2"; 4'd3: return "R3";
      4'd7: return "R7"; 4'd11: return "R11";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    step();
    we = 1'b0; wdata = '0;
  endtask

  task automatic pulse(input logic [7:0] e);
    ev = e; step(); ev = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R5 reset values
    rd(2'd0, v); chk("R5", "status reset", v, 8'h00);
    rd(2'd1, v); chk("R5", "mask reset", v, 8'h00);
    rd(2'd2, v); chk("R5", "control reset", v, 8'h06);
    chk("R5", "irq reset", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd2, v); chk("R5", "control after release", v, 8'h06);
    chk("R5", "pdwn/fsusp", {6'd0, pdwn, fsusp}, 8'h03);

    for (int i = 0; i < NV; i++) begin
      ev = VEC[i][28:21];
      we = VEC[i][20];
      addr = 2'd0;
      wdata = VEC[i][19:12];
      step();
      ev = '0; we = 1'b0; wdata = '0;
      rd(2'd0, v);
      chk(rq(VEC[i][3:0]), $sformatf("table %0d", i), v, VEC[i][11:4]);
    end
    chk("R7", "fsusp cleared by activity", {7'd0, fsusp}, 8'h00);

    // R6 reserved bits and unused address
    wr(2'd2, 8'hF0);
    rd(2'd2, v); chk("R6", "control reserved", v, 8'h00);
    rd(2'd3, v); chk("R6", "address 3", v, 8'h00);

    // R9 forced reset
    wr(2'd2, 8'h01);
    chk("R9", "epreg_clr held", {7'd0, epclr}, 8'h01);
    pulse(8'h32);
    rd(2'd0, v); chk("R9", "events ignored", v, 8'h00);
    wr(2'd2, 8'h00);
    rd(2'd0, v); chk("R9", "release sets reset bit", v, 8'h02);
    chk("R9", "epreg_clr released", {7'd0, epclr}, 8'h00);

    // R4 interrupt request
    wr(2'd1, 8'h02);
    rd(2'd1, v); chk("R4", "mask readback", v, 8'h02);
    chk("R4", "irq on", {7'd0, irq}, 8'h01);
    dis = 1'b1; #1 chk("R4", "irq disabled", {7'd0, irq}, 8'h00);
    dis = 1'b0;
    wr(2'd0, 8'hFD);
    chk("R4", "irq after clear", {7'd0, irq}, 8'h00);

    // R8 wake request, R7 suspend exit
    wr(2'd1, 8'h04);
    wr(2'd2, 8'h02);
    chk("R7", "fsusp set", {7'd0, fsusp}, 8'h01);
    chk("R8", "wake idle", {7'd0, wake}, 8'h00);
    pulse(8'h08);
    chk("R7", "fsusp cleared", {7'd0, fsusp}, 8'h00);
    chk("R8", "wake on", {7'd0, wake}, 8'h01);
    dis = 1'b1; #1 chk("R8", "wake ignores disable", {7'd0, wake}, 8'h01);
    dis = 1'b0;
    wr(2'd0, 8'h00);
    chk("R8", "wake cleared", {7'd0, wake}, 8'h00);

    // R12 resume
    wr(2'd2, 8'h08);
    chk("R12", "resume on", {7'd0, resume}, 8'h01);
    pulse(8'hFF);
    chk("R12", "resume kept", {7'd0, resume}, 8'h01);
    wr(2'd2, 8'h00);
    chk("R12", "resume off", {7'd0, resume}, 8'h00);
    wr(2'd0, 8'h00);

    // R10 bus reset clears endpoint registers
    ev = 8'h04; #1 chk("R10", "epreg_clr on bus reset", {7'd0, epclr}, 8'h01);
    step(); ev = '0;
    rd(2'd0, v); chk("R10", "reset status bit", v, 8'h02);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule